// File: doc/BRIEF.md
# Chainable Two-Section Decade Counter

This block is a synchronous model of a decade counter split into two sections. One section holds a single bit and divides by two. The other holds a three-bit code and divides by five. Each section has its own count pin. Both pins are asynchronous to the system clock, so each is synchronised and then watched for a high-to-low transition. A two-bit wiring input sets how the sections are joined:

- **Split:** the sections run independently.
- **BCD:** the single-bit stage carries into the five-state stage, and the four outputs count in plain binary from 0 to 9.
- **Bi-quinary:** the five-state stage carries into the single-bit stage. This makes the single-bit output a symmetric square wave at one tenth of the input rate.

Two AND-gated preset pairs act on the clock edge at which they are seen. One pair loads nine and the other clears. The load-nine pair wins when both pairs are active.

The output `digit_o` is registered. Bit 0 is the divide-by-two stage. Bits 3:1 are the divide-by-five code, with bit 3 as its most significant bit.

Top module: `bqc_top`

## Requirements
- R1: When the synchronous active-high `rst` is high at a clock edge, all four bits of `digit_o` become 0.
- R2: With wiring = 0 (split) or 3 (treated as split), every high-to-low transition on `cnt_lo` inverts `digit_o[0]`. This happens within a few clock cycles and exactly once per transition.
- R3: With wiring = 0 or 3, every high-to-low transition on `cnt_hi` steps `digit_o[3:1]` through the order 000, 001, 010, 011, 100 and then back to 000.
- R4: With wiring = 1 (BCD), falls on `cnt_lo` make `digit_o` count in binary 0,1,...,9 and then 0. In this mode `cnt_hi` has no effect.
- R5: With wiring = 2 (bi-quinary), falls on `cnt_hi` step `digit_o[3:1]` as in R3. `digit_o[0]` inverts each time that code wraps from 100 to 000, so it is high for counts 5 to 9 of each ten. In this mode `cnt_lo` has no effect.
- R6: When `nine_a` and `nine_b` are both high at a clock edge, `digit_o` becomes 4'b1001. This holds whatever the clear pins are.
- R7: When `clr_a` and `clr_b` are both high and the nine pair is not both high, `digit_o` becomes 0 at that edge.
- R8: A single high pin of either gated pair has no effect, and counting continues as normal.
- R9: The following have no effect:
  - count-pin transitions that occur while a preset is active;
  - bit changes caused by a preset, which never produce a carry into the other section.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wiring | input | 2 | 0 split, 1 BCD, 2 bi-quinary, 3 split |
| cnt_lo | input | 1 | Asynchronous count pin of the divide-by-two stage |
| cnt_hi | input | 1 | Asynchronous count pin of the divide-by-five stage |
| clr_a | input | 1 | Clear pair, first pin |
| clr_b | input | 1 | Clear pair, second pin |
| nine_a | input | 1 | Load-nine pair, first pin |
| nine_b | input | 1 | Load-nine pair, second pin |
| digit_o | output | 4 | Registered count; bit 0 is the divide-by-two stage |

## Verification
The bench builds the counter with three synchroniser stages instead of the default two. This lengthens the path from pin to count, so the carry between sections lands one cycle later again. A count pulse therefore has to be settled before the bench compares its model. Random pulses, wiring changes (the spare code included) and partial or full preset combinations walk through every BCD and bi-quinary state. Directed sequences cover the 9-to-0 wrap, the bi-quinary square wave, load-nine priority, and a preset that lowers bit 0 without causing a carry.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
  typedef enum logic [1:0] {
    WIRE_SPLIT = 2'd0,
    WIRE_BCD   = 2'd1,
    WIRE_BIQ   = 2'd2,
    WIRE_SPARE = 2'd3
  } wiring_e;

  localparam int unsigned HI_MOD = 5;
endpackage

// File: rtl/bqc_fall_detect.sv
module bqc_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign fall = prev_q & ~sync_q[LAST];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R2
endmodule

// File: rtl/bqc_div2.sv
module bqc_div2 (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic load,
  input  logic load_val,
  output logic q,
  output logic wrap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      wrap_o <= 1'b0;
    end else if (load) begin
      q      <= load_val;
      wrap_o <= 1'b0;
    end else begin
      if (step) q <= ~q;
      wrap_o <= step & q;
    end
  end

  AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (q != $past(q))); // R2
endmodule

// File: rtl/bqc_div5.sv
module bqc_div5 #(
  parameter int unsigned MOD = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     load,
  input  logic                     load_top,
  output logic [$clog2(MOD)-1:0]   cnt,
  output logic                     wrap_o
);
  localparam int unsigned W = $clog2(MOD);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wrap_o <= 1'b0;
    end else if (load) begin
      cnt    <= load_top ? TOP : '0;
      wrap_o <= 1'b0;
    end else begin
      if (step) cnt <= at_top ? '0 : cnt + 1'b1;
      wrap_o <= step & at_top;
    end
  end

  AST_DIV5_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt == TOP) |=> (cnt == '0)); // R3
endmodule

// File: rtl/bqc_top.sv
module bqc_top #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] wiring,
  input  logic       cnt_lo,
  input  logic       cnt_hi,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic [3:0] digit_o
);
  import bqc_pkg::*;

  localparam int unsigned HW = $clog2(HI_MOD);

  wiring_e        mode;
  logic           fall_lo, fall_hi;
  logic           nine_act, clr_act, load;
  logic           step_lo, step_hi;
  logic           lo_q, lo_wrap;
  logic [HW-1:0]  hi_cnt;
  logic           hi_wrap;

  assign mode = wiring_e'(wiring);

  bqc_fall_detect #(.STAGES(SYNC_STAGES)) u_fd_lo (
    .clk(clk), .rst(rst), .pin(cnt_lo), .fall(fall_lo));

  bqc_fall_detect #(.STAGES(SYNC_STAGES)) u_fd_hi (
    .clk(clk), .rst(rst), .pin(cnt_hi), .fall(fall_hi));

  // load-nine pair outranks the clear pair
  assign nine_act = nine_a & nine_b;
  assign clr_act  = clr_a & clr_b & ~nine_act;
  assign load     = nine_act | clr_act;

  always_comb begin
    step_lo = fall_lo;
    step_hi = fall_hi;
    case (mode)
      WIRE_BCD: step_hi = lo_wrap;
      WIRE_BIQ: step_lo = hi_wrap;
      default: ;
    endcase
  end

  bqc_div2 u_lo (
    .clk(clk), .rst(rst), .step(step_lo), .load(load),
    .load_val(nine_act), .q(lo_q), .wrap_o(lo_wrap));

  bqc_div5 #(.MOD(HI_MOD)) u_hi (
    .clk(clk), .rst(rst), .step(step_hi), .load(load),
    .load_top(nine_act), .cnt(hi_cnt), .wrap_o(hi_wrap));

  assign digit_o = {hi_cnt, lo_q};

  AST_NINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (nine_a && nine_b) |=> (digit_o == 4'b1001)); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b && !(nine_a && nine_b)) |=> (digit_o == 4'b0000)); // R7
endmodule

// File: tb/sim_bqc_top.sv
module sim_bqc_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] wiring = 2'd0;
  logic       cnt_lo = 1'b1, cnt_hi = 1'b1;
  logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
  logic [3:0] digit_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] exp_st = 4'd0;

  always #10 clk = ~clk;

  bqc_top #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst(rst), .wiring(wiring), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
    .digit_o(digit_o));

  function automatic logic [3:0] step_hi5(input logic [3:0] s);
    logic [2:0] q;
    q = s[3:1];
    q = (q == 3'd4) ? 3'd0 : q + 3'd1;
    return {q, s[0]};
  endfunction

  function automatic logic [3:0] model_step(input logic [3:0] s,
                                            input logic [1:0] m,
                                            input bit on_lo);
    logic [3:0] n;
    n = s;
    case (m)
      2'd1: if (on_lo) begin
              if (s[0]) n = step_hi5({s[3:1], 1'b0});
              else      n = {s[3:1], 1'b1};
            end
      2'd2: if (!on_lo) begin
              n = step_hi5(s);
              if (s[3:1] == 3'd4) n[0] = ~s[0];
            end
      default: n = on_lo ? {s[3:1], ~s[0]} : step_hi5(s);
    endcase
    return n;
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    n_tests++;
    if (digit_o !== exp) begin
      n_fail++;
      $display("FAIL %s: digit_o=%b expected=%b", tag, digit_o, exp);
    end
  endtask

  task automatic pulse(input bit on_lo);
    if (on_lo) cnt_lo = 1'b0; else cnt_hi = 1'b0;
    repeat (6) @(negedge clk);
    if (on_lo) cnt_lo = 1'b1; else cnt_hi = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic stepm(input bit on_lo, input string tag);
    pulse(on_lo);
    exp_st = model_step(exp_st, wiring, on_lo);
    check(exp_st, tag);
  endtask

  task automatic presets(input logic [3:0] p, input string tag);
    {clr_a, clr_b, nine_a, nine_b} = p;
    repeat (2) @(negedge clk);
    if (p[1] && p[0])      exp_st = 4'b1001;
    else if (p[3] && p[2]) exp_st = 4'b0000;
    check(exp_st, tag);
    {clr_a, clr_b, nine_a, nine_b} = 4'b0000;
    repeat (4) @(negedge clk);
    check(exp_st, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(4'd0, "R1 reset");

    // split: R2 / R3
    wiring = 2'd0;
    stepm(1'b1, "R2 lo toggle");
    stepm(1'b1, "R2 lo toggle back");
    for (int i = 0; i < 6; i++) stepm(1'b0, "R3 div5 sequence");

    // BCD: full decade and wrap, cnt_hi ignored
    presets(4'b1100, "R7 clear");
    wiring = 2'd1;
    for (int i = 0; i < 11; i++) begin
      stepm(1'b1, "R4 bcd count");
      if (digit_o > 4'd9) begin
        n_tests++; n_fail++;
        $display("FAIL R4: digit_o=%0d expected<=9", digit_o);
      end
    end
    stepm(1'b0, "R4 cnt_hi ignored");

    // bi-quinary: square wave
    presets(4'b1100, "R7 clear");
    wiring = 2'd2;
    for (int i = 0; i < 5; i++) stepm(1'b0, "R5 biq count");
    check(4'b0001, "R5 high half");
    for (int i = 0; i < 5; i++) stepm(1'b0, "R5 biq count");
    check(4'b0000, "R5 low half");
    stepm(1'b1, "R5 cnt_lo ignored");

    // presets
    presets(4'b1111, "R6 nine over clear");
    presets(4'b1000, "R8 single clear pin");
    stepm(1'b0, "R8 counting continues");
    presets(4'b0010, "R8 single nine pin");

    // R9: preset lowering bit0 in BCD mode creates no carry
    wiring = 2'd1;
    presets(4'b0011, "R6 nine");
    presets(4'b1100, "R9 no carry from clear");
    repeat (6) @(negedge clk);
    check(4'd0, "R9 still zero");
    // R9: count edges during an active clear are ignored
    clr_a = 1'b1; clr_b = 1'b1;
    pulse(1'b1);
    check(4'd0, "R9 edge during clear");
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (6) @(negedge clk);
    check(4'd0, "R9 edge ignored");

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 300; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 4)      stepm(1'b1, "R2 R4 random lo");
      else if (r < 8) stepm(1'b0, "R3 R5 random hi");
      else if (r == 8) wiring = 2'($urandom % 4);
      else            presets(4'($urandom), "R6 R7 R8 random preset");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: expired expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule